// File: doc/BRIEF.md
# Receive Character Timeout Detector

This block sits beside a receive FIFO and raises a level flag when at least one character is waiting and the line has been quiet for a set time. The block takes the receive sampling tick, which runs at sixteen times the baud rate. It counts only those ticks. Any push into the FIFO, pop from it or change in its fill count starts the idle period again. When enough ticks pass with no activity, the flag rises. It stays high until a receive buffer read clears it or the FIFO runs empty.

The quiet time is not fixed. It is worked out again from the configured character width, the trigger level and the current fill count each time the idle period restarts. The time is longer when the FIFO is further below its trigger level. This gives roughly three and a half to four and a half character times. The FIFO storage, the deserializer and the interrupt priority logic are outside this block.

Top module: `rx_char_timeout`

## Requirements
- R1: While `fifo_count_i` is 0 the detector is idle. `timeout_o` is low from the next clock on, and no timeout can start until the count is 1 or more.
- R2: A cycle with `push_i` or `pop_i` high restarts the idle period. The full timeout length is counted again from that cycle.
- R3: The timeout length, in ticks, is (B×7−2)×8 + G×8 + 1. B is the character width, where `word_len_i` codes 0, 1, 2 and 3 mean 5, 6, 7 and 8 bits. G is `trig_lvl_i` minus `fifo_count_i`.
- R4: When `fifo_count_i` is equal to or above `trig_lvl_i`, G is taken as 0. The length is then (B×7−2)×8 + 1 and never wraps.
- R5: A cycle with `rd_clr_i` high forces `timeout_o` low on the following clock. If this cycle is also the expiry cycle, the clear wins.
- R6: A change of `fifo_count_i` without any strobe also restarts the idle period. The length is recomputed from the new count.
- R7: `timeout_o` rises on the clock edge that carries the N-th tick after the last restart, where N is the length from R3/R4. It then holds high with no further activity. After an expiry it does not rise again until a new restart.
- R8: Clock cycles with `rclk_tick_i` low do not advance the timeout count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| rclk_tick_i | input | 1 | Receive sampling tick (16x baud), one clock wide |
| word_len_i | input | 2 | Character width code: 0..3 means 5..8 bits |
| trig_lvl_i | input | CNT_W (5) | FIFO trigger level in characters |
| fifo_count_i | input | CNT_W (5) | Current number of characters in the receive FIFO |
| push_i | input | 1 | Strobe: a character was written into the FIFO |
| pop_i | input | 1 | Strobe: a character was removed from the FIFO |
| rd_clr_i | input | 1 | Receive buffer read; clears the flag |
| timeout_o | output | 1 | Character timeout flag, level held |

## Verification
The hardest case to reach is a clear that lands on the very clock edge where the count expires. Reaching it takes an exact count of hundreds of ticks since the last restart. The bench first measures each timeout length tick by tick for every character width, on both sides of the trigger level. It then uses that known length to place the clear on the expiry edge. A restart caused by the count alone, with no strobe, and a sparse tick pattern are also driven. A behavioural model built on plain integers is compared on every cycle.

// File: rtl/rx_tmo_pkg.sv
package rx_tmo_pkg;

    typedef enum logic [1:0] {
        WL_5 = 2'd0,
        WL_6 = 2'd1,
        WL_7 = 2'd2,
        WL_8 = 2'd3
    } wlen_e;

    typedef struct packed {
        logic restart;
        logic armed;
    } tmo_ctl_t;

    localparam int unsigned TICKS_PER_GAP = 8;

    function automatic int unsigned char_bits(wlen_e code);
        return 5 + int'(code);
    endfunction

    function automatic int unsigned base_ticks(wlen_e code);
        return (char_bits(code) * 7 - 2) * TICKS_PER_GAP;
    endfunction

    function automatic int unsigned max_len(int unsigned cnt_w);
        return base_ticks(WL_8) + ((1 << cnt_w) - 1) * TICKS_PER_GAP + 1;
    endfunction

endpackage

// File: rtl/tmo_len_calc.sv
module tmo_len_calc
    import rx_tmo_pkg::*;
#(
    parameter int CNT_W = 5,
    parameter int LEN_W = 10
) (
    input  wlen_e              wlen_i,
    input  logic [CNT_W-1:0]   trig_i,
    input  logic [CNT_W-1:0]   count_i,
    output logic [LEN_W-1:0]   len_o
);
    logic [CNT_W-1:0] gap;
    logic [LEN_W-1:0] base;
    logic [LEN_W-1:0] gap_ticks;

    always_comb begin
        gap       = (trig_i > count_i) ? (trig_i - count_i) : '0;
        base      = LEN_W'(base_ticks(wlen_i));
        gap_ticks = LEN_W'({gap, 3'b000});
        len_o     = base + gap_ticks + LEN_W'(1);
    end
endmodule

// File: rtl/tmo_activity.sv
module tmo_activity
    import rx_tmo_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [CNT_W-1:0] count_i,
    output tmo_ctl_t         ctl_o
);
    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) count_q <= '0;
        else     count_q <= count_i;
    end

    always_comb begin
        ctl_o.armed   = (count_i != '0);
        ctl_o.restart = push_i | pop_i | (count_i != count_q);
    end

    // R6: an armed count change with no strobe still restarts the idle period
    a_r6_count_change_restarts: assert property (@(posedge clk) disable iff (rst)
        (ctl_o.armed && (count_i != $past(count_i))) |-> ctl_o.restart);

    // R2: each strobe restarts the idle period
    a_r2_strobe_restarts: assert property (@(posedge clk) disable iff (rst)
        (push_i || pop_i) |-> ctl_o.restart);
endmodule

// File: rtl/tmo_counter.sv
module tmo_counter
    import rx_tmo_pkg::*;
#(
    parameter int LEN_W   = 10,
    parameter int MIN_LEN = 265
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             clr_i,
    input  tmo_ctl_t         ctl_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             flag_o
);
    logic [LEN_W-1:0] cnt_q;
    logic             expire;

    assign expire = ctl_i.armed && !ctl_i.restart && tick_i && (cnt_q == LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            flag_o <= 1'b0;
        end else begin
            if (!ctl_i.armed)            cnt_q <= '0;
            else if (ctl_i.restart)      cnt_q <= len_i;
            else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - LEN_W'(1);

            if (!ctl_i.armed || clr_i)   flag_o <= 1'b0;
            else if (expire)             flag_o <= 1'b1;
        end
    end

    // R1: empty FIFO leaves the counter idle and the flag low
    a_r1_idle_when_empty: assert property (@(posedge clk) disable iff (rst)
        !ctl_i.armed |=> (cnt_q == '0 && !flag_o));

    // R2: a restart loads the computed length
    a_r2_reload_length: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.armed && ctl_i.restart) |=> (cnt_q == $past(len_i)));

    // R4: length never drops below the clamped floor
    a_r4_len_floor: assert property (@(posedge clk) disable iff (rst)
        ctl_i.armed |-> (len_i >= LEN_W'(MIN_LEN)));

    // R5: a read clears the flag on the next clock
    a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> !flag_o);

    // R7: the flag rises only out of the last tick of a running count
    a_r7_rise_on_last_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_o) |-> ($past(cnt_q) == LEN_W'(1) && $past(tick_i)));

    // R8: no tick, no progress
    a_r8_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.armed && !ctl_i.restart && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/rx_char_timeout.sv
module rx_char_timeout
    import rx_tmo_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rclk_tick_i,
    input  logic [1:0]       word_len_i,
    input  logic [CNT_W-1:0] trig_lvl_i,
    input  logic [CNT_W-1:0] fifo_count_i,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic             rd_clr_i,
    output logic             timeout_o
);
    localparam int unsigned MAX_LEN = max_len(CNT_W);
    localparam int LEN_W   = $clog2(MAX_LEN + 1);
    localparam int MIN_LEN = int'(base_ticks(WL_5)) + 1;

    wlen_e            wlen;
    tmo_ctl_t         ctl;
    logic [LEN_W-1:0] len;

    assign wlen = wlen_e'(word_len_i);

    tmo_len_calc #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_len (
        .wlen_i  (wlen),
        .trig_i  (trig_lvl_i),
        .count_i (fifo_count_i),
        .len_o   (len)
    );

    tmo_activity #(.CNT_W(CNT_W)) u_act (
        .clk     (clk),
        .rst     (rst),
        .push_i  (push_i),
        .pop_i   (pop_i),
        .count_i (fifo_count_i),
        .ctl_o   (ctl)
    );

    tmo_counter #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .tick_i (rclk_tick_i),
        .clr_i  (rd_clr_i),
        .ctl_i  (ctl),
        .len_i  (len),
        .flag_o (timeout_o)
    );
endmodule

// File: tb/rx_char_timeout_test.sv
module rx_char_timeout_test;
    localparam int CNT_W = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic [1:0] wl = 2'd0;
    logic [CNT_W-1:0] trig = '0;
    logic [CNT_W-1:0] cnt = '0;
    logic push = 1'b0, pop = 1'b0, clr = 1'b0;
    logic timeout;

    int checks = 0;
    int fails = 0;
    int tper = 1;
    int phase = 0;
    int ticks_sent = 0;
    bit done = 0;

    // behavioural reference state
    int m_rem = 0;
    bit m_flag = 0;
    int m_pcnt = 0;

    always #2 clk = ~clk;

    rx_char_timeout #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst(rst), .rclk_tick_i(tick), .word_len_i(wl),
        .trig_lvl_i(trig), .fifo_count_i(cnt), .push_i(push), .pop_i(pop),
        .rd_clr_i(clr), .timeout_o(timeout)
    );

    function automatic int exp_len(int w, int t, int c);
        int g;
        g = (t > c) ? t - c : 0;
        return ((5 + w) * 7 - 2) * 8 + g * 8 + 1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_rem = 0; m_flag = 0; m_pcnt = 0;
        end else begin
            bit rs, ex;
            rs = push || pop || (int'(cnt) != m_pcnt);
            ex = 0;
            if (cnt == 0) begin
                m_rem = 0; m_flag = 0;
            end else begin
                if (rs) m_rem = exp_len(int'(wl), int'(trig), int'(cnt));
                else if (tick && m_rem > 0) begin
                    if (m_rem == 1) ex = 1;
                    m_rem = m_rem - 1;
                end
                if (clr) m_flag = 0;
                else if (ex) m_flag = 1;
            end
            m_pcnt = int'(cnt);
        end
    end

    // per-cycle comparison against the model (covers R1..R8 continuously)
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (timeout !== m_flag) begin
                fails++;
                $display("FAIL R7 cycle compare: timeout=%0b expected %0b", timeout, m_flag);
            end
        end
    end

    task automatic check(string req, int act, int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic step();
        tick = (phase == 0);
        phase = (phase + 1) % tper;
        @(posedge clk);
        #1;
        if (tick) ticks_sent++;
        push = 0; pop = 0; clr = 0; tick = 0;
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    // count ticks from now until the flag rises
    task automatic measure(output int got);
        ticks_sent = 0;
        got = -1;
        for (int i = 0; i < 3000; i++) begin
            step();
            if (timeout) begin got = ticks_sent; break; end
        end
    endtask

    task automatic load(int w, int t, int c);
        wl = 2'(w); trig = CNT_W'(t); cnt = CNT_W'(c); push = 1;
        phase = 0;
        step();
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int got;
        repeat (3) @(posedge clk);
        #1;
        rst = 0;
        check("R1 reset state", int'(timeout), 0);
        steps(20);
        check("R1 empty fifo stays idle", int'(timeout), 0);

        // R3: every character width, trigger 8, one character held
        for (int w = 0; w < 4; w++) begin
            cnt = 0; step(); step();
            load(w, 8, 1);
            measure(got);
            check("R3 length per word width", got, exp_len(w, 8, 1));
        end

        // R4: at and above trigger, gap term clamped
        cnt = 0; step(); step();
        load(3, 4, 10);
        measure(got);
        check("R4 count above trigger", got, 433);
        cnt = 0; step(); step();
        load(3, 4, 4);
        measure(got);
        check("R4 count equal to trigger", got, 433);

        // R7: held high, then no re-rise after clear
        steps(50);
        check("R7 flag held", int'(timeout), 1);
        clr = 1; step();
        check("R5 read clears flag", int'(timeout), 0);
        steps(800);
        check("R7 no second rise without restart", int'(timeout), 0);

        // R2: pop mid-wait restarts
        cnt = 0; step(); step();
        load(0, 1, 1);
        steps(100);
        pop = 1; step();
        measure(got);
        check("R2 pop restarts idle period", got, 265);

        // R2: push mid-wait restarts
        cnt = 0; step(); step();
        load(1, 1, 1);
        steps(200);
        push = 1; step();
        measure(got);
        check("R2 push restarts idle period", got, 321);

        // R6: count change without strobe
        cnt = 0; step(); step();
        load(0, 8, 1);
        steps(100);
        cnt = 2; step();
        measure(got);
        check("R6 count change recomputes length", got, exp_len(0, 8, 2));

        // R1: fifo drains while flag high
        cnt = 0; step();
        check("R1 empty fifo drops flag", int'(timeout), 0);

        // R5: clear on the expiry edge wins
        step();
        load(0, 1, 1);
        steps(264);
        check("R5 not yet expired", int'(timeout), 0);
        clr = 1; step();
        check("R5 clear beats expiry", int'(timeout), 0);
        steps(20);
        check("R5 stays low after coincident clear", int'(timeout), 0);

        // R8: sparse ticks
        cnt = 0; step(); step();
        tper = 3;
        load(0, 1, 1);
        measure(got);
        check("R8 only ticks advance count", got, 265);
        tper = 1;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule